// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one group of sixteen lane load requests at a time. Each lane has an enable bit and a byte address, and one element-size code applies to the whole group. The block turns the group into the shortest list of aligned memory segment transactions that serves every enabled lane. Each transaction names an aligned base address, a segment size, and the mask of lanes whose data lies inside it. A load/store unit places the block between its lane address generators and the memory request queue. The block issues one transaction per cycle over a valid/ready handshake. When no lane is left waiting, it raises a one-cycle completion pulse.

Transactions are built one at a time. Each one is formed around the lowest-numbered lane still waiting. The segment that holds this lane's address is found, and every other waiting lane in the same segment joins the transaction. The transaction is then shrunk to the smallest aligned piece that still holds all of its lanes. In strict mode, the group is merged only when it forms a perfectly ordered, aligned run. Otherwise every lane gets a transaction of its own.

Top module: `hw_coalescer`

## Requirements
- R1: After reset `grp_ready` is 1, `txn_valid` is 0 and `grp_done` is 0. A group is taken when `grp_valid` and `grp_ready` are both high, and `grp_ready` stays low until that group has completed.
- R2: The starting segment size depends on the element code `grp_elem`: code 0 (1 byte) gives 32 B, code 1 (2 bytes) gives 64 B, and codes 2 (4 bytes) and 3 (8 bytes) give 128 B. `txn_size` reports the size as 0 = 32 B, 1 = 64 B, 2 = 128 B.
- R3: Every transaction contains the lowest-numbered lane that is still waiting. Its base is that lane's address rounded down to the transaction size.
- R4: When strict mode is off, every waiting lane whose address lies in the same starting-size aligned segment as the leading lane is served by that transaction.
- R5: A 128 B segment shrinks to 64 B when all of its lanes lie in one aligned 64 B half, and then to 32 B when they also lie in one aligned 32 B quarter. A 64 B segment shrinks to 32 B in the same way. No transaction is smaller than 32 B.
- R6: A transaction is transferred on a cycle where `txn_valid` and `txn_ready` are both high. While it is held back by `txn_ready` low, `txn_base`, `txn_size` and `txn_mask` do not change.
- R7: A lane is served exactly once. `grp_done` is high for exactly one cycle, and that cycle is the cycle after the transfer that serves the last waiting lane.
- R8: A group with no enabled lanes produces no transaction. `grp_done` rises in the first cycle after the group is taken.
- R9: In strict mode, let B be the first enabled lane's address rounded down to the starting segment size and E the element size in bytes. If every enabled lane k has address B + k·E, the group is merged as in R4 and R5. If not, each enabled lane is issued as its own 32 B transaction, in ascending lane order.
- R10: Address bits below the element size are ignored, so each address is treated as rounded down to a multiple of the element size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_valid | input | 1 | A request group is offered |
| grp_ready | output | 1 | The block is idle and takes a group |
| grp_active | input | LANES | Lane enable bits |
| grp_addr | input | LANES*AW | Lane byte addresses; lane k is in bits [k*AW +: AW] |
| grp_elem | input | 2 | Element size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| grp_strict | input | 1 | Strict ordered-run merging |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | The memory side takes the transaction |
| txn_base | output | AW | Aligned segment base address |
| txn_size | output | 2 | Segment size: 0=32 B, 1=64 B, 2=128 B |
| txn_mask | output | LANES | Lanes served by this transaction |
| grp_done | output | 1 | One-cycle pulse when the group is fully served |

## Verification
Two events can fall in the same cycle: a transfer that is stalled by `txn_ready` and the transfer that empties the group's waiting set. When they meet, the completion pulse must wait for the stalled final transaction to be taken, and it must then follow in the very next cycle. The bench drives `txn_ready` from a pseudo-random pattern across every access shape, element size and strictness setting. This lands stalls on final transfers many times. Each transfer is judged against an independently computed list of transactions. A transaction that is still offered while stalled is compared with its previous cycle, and the completion pulse is required exactly one cycle after the last transfer.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    SEG32  = 2'd0,
    SEG64  = 2'd1,
    SEG128 = 2'd2
  } seg_t;

  // starting segment size chosen by the element size code
  function automatic seg_t seg_for_elem(input logic [1:0] elem);
    case (elem)
      2'd0:    return SEG32;
      2'd1:    return SEG64;
      default: return SEG128;
    endcase
  endfunction

  // log2 of segment bytes
  function automatic int unsigned seg_shift(input seg_t s);
    return 5 + int'(s);
  endfunction

  // true when a and b sit in the same aligned block of 2**sh bytes
  function automatic logic same_block(input logic [63:0] a, input logic [63:0] b,
                                      input int unsigned sh);
    return ((a ^ b) >> sh) == 64'd0;
  endfunction

  // round address down to 2**sh
  function automatic logic [63:0] align_down(input logic [63:0] a, input int unsigned sh);
    return (a >> sh) << sh;
  endfunction

endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES = 16,
  localparam int IW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pending,
  output logic [IW-1:0]    lead_idx,
  output logic [LANES-1:0] lead_oh,
  output logic             any_pending
);
  always_comb begin
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) lead_idx = IW'(i);
    end
  end

  assign lead_oh     = pending & (~pending + LANES'(1));
  assign any_pending = |pending;
endmodule

// File: rtl/coal_match.sv
module coal_match
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES-1:0]    pending,
  input  logic [AW-1:0]       lead_addr,
  input  seg_t                seg0,
  output logic [LANES-1:0]    member,
  output logic                fit64,
  output logic                fit32
);
  logic [LANES-1:0] in64, in32;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [63:0] a, l;
    assign a = 64'(addr_flat[g*AW +: AW]);
    assign l = 64'(lead_addr);
    assign member[g] = pending[g] && same_block(a, l, seg_shift(seg0));
    assign in64[g]   = same_block(a, l, 6);
    assign in32[g]   = same_block(a, l, 5);
  end

  assign fit64 = &(~member | in64);
  assign fit32 = &(~member | in32);
endmodule

// File: rtl/coal_strict.sv
module coal_strict
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES-1:0]    active,
  input  logic [1:0]          elem,
  output logic                ordered_ok
);
  logic [AW-1:0] first_addr, run_base;

  always_comb begin
    first_addr = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (active[i]) first_addr = addr_flat[i*AW +: AW];
    end
  end

  assign run_base = AW'(align_down(64'(first_addr), seg_shift(seg_for_elem(elem))));

  always_comb begin
    ordered_ok = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (active[k] && (addr_flat[k*AW +: AW] != run_base + (AW'(k) << elem)))
        ordered_ok = 1'b0;
    end
  end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int IW = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grp_valid,
  output logic                grp_ready,
  input  logic [LANES-1:0]    grp_active,
  input  logic [LANES*AW-1:0] grp_addr,
  input  logic [1:0]          grp_elem,
  input  logic                grp_strict,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [1:0]          txn_size,
  output logic [LANES-1:0]    txn_mask,
  output logic                grp_done
);
  // element-aligned copy of the incoming addresses (R10)
  logic [LANES*AW-1:0] addr_al;
  for (genvar g = 0; g < LANES; g++) begin : g_align
    assign addr_al[g*AW +: AW] = (grp_addr[g*AW +: AW] >> grp_elem) << grp_elem;
  end

  logic ordered_ok;
  coal_strict #(.LANES(LANES), .AW(AW)) u_strict (
    .addr_flat(addr_al), .active(grp_active), .elem(grp_elem), .ordered_ok(ordered_ok)
  );

  // group state
  logic                busy_q, split_q;
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  seg_t                seg0_q;

  // named internal events
  logic grp_accept, txn_fire, grp_empty;
  assign grp_ready  = !busy_q;
  assign grp_accept = grp_valid && grp_ready;
  assign grp_empty  = busy_q && (pend_q == '0);
  assign txn_fire   = txn_valid && txn_ready;

  logic [IW-1:0]    lead_idx;
  logic [LANES-1:0] lead_oh;
  logic             any_pending;
  coal_leader #(.LANES(LANES)) u_leader (
    .pending(pend_q), .lead_idx(lead_idx), .lead_oh(lead_oh), .any_pending(any_pending)
  );

  logic [AW-1:0] lead_addr;
  assign lead_addr = addr_q[lead_idx*AW +: AW];

  logic [LANES-1:0] member;
  logic             fit64, fit32;
  coal_match #(.LANES(LANES), .AW(AW)) u_match (
    .addr_flat(addr_q), .pending(pend_q), .lead_addr(lead_addr), .seg0(seg0_q),
    .member(member), .fit64(fit64), .fit32(fit32)
  );

  // final size after shrinking
  seg_t fin_seg;
  always_comb begin
    fin_seg = seg0_q;
    if (split_q) fin_seg = SEG32;
    else if (seg0_q == SEG128 && fit64) fin_seg = fit32 ? SEG32 : SEG64;
    else if (seg0_q == SEG64 && fit32) fin_seg = SEG32;
  end

  assign txn_valid = busy_q && any_pending;
  assign txn_mask  = split_q ? lead_oh : member;
  assign txn_size  = fin_seg;
  assign txn_base  = AW'(align_down(64'(lead_addr), seg_shift(fin_seg)));
  assign grp_done  = grp_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      split_q <= 1'b0;
      pend_q  <= '0;
      addr_q  <= '0;
      seg0_q  <= SEG32;
    end else if (grp_accept) begin
      busy_q  <= 1'b1;
      split_q <= grp_strict && !ordered_ok;
      pend_q  <= grp_active;
      addr_q  <= addr_al;
      seg0_q  <= seg_for_elem(grp_elem);
    end else if (txn_fire) begin
      pend_q <= pend_q & ~txn_mask;
    end else if (grp_empty) begin
      busy_q <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> grp_ready);

  assert_size_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_size != 2'd3));

  assert_leader_served_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & lead_oh) != '0));

  assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_size == 2'd0 && txn_base[4:0] == 5'd0) ||
                   (txn_size == 2'd1 && txn_base[5:0] == 6'd0) ||
                   (txn_size == 2'd2 && txn_base[6:0] == 7'd0)));

  assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=>
      (txn_valid && $stable(txn_base) && $stable(txn_size) && $stable(txn_mask)));

  assert_only_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & ~pend_q) == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done);

  assert_split_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && split_q) |-> ($countones(txn_mask) == 1 && txn_size == 2'd0));
endmodule

// File: tb/tb_hw_coalescer.sv
module tb_hw_coalescer;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                grp_valid = 1'b0, grp_ready;
  logic [LANES-1:0]    grp_active = '0;
  logic [LANES*AW-1:0] grp_addr = '0;
  logic [1:0]          grp_elem = '0;
  logic                grp_strict = 1'b0;
  logic                txn_valid, txn_ready = 1'b0;
  logic [AW-1:0]       txn_base;
  logic [1:0]          txn_size;
  logic [LANES-1:0]    txn_mask;
  logic                grp_done;

  hw_coalescer #(.LANES(LANES), .AW(AW)) dut (.*);

  int checks = 0, fails = 0;
  int unsigned lfsr = 32'h1ACE_B00C;

  function automatic int unsigned nxt(input int unsigned s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected transaction list
  int unsigned e_base[LANES];
  int unsigned e_size[LANES];
  int unsigned e_mask[LANES];
  int          e_n;

  task automatic model(input logic [15:0] act, input int unsigned ad[LANES],
                       input int elem, input logic strict);
    int unsigned a[LANES];
    int unsigned E, S0, pend, B;
    logic ok;
    int f;
    E = 1 << elem;
    S0 = (elem == 0) ? 32 : (elem == 1) ? 64 : 128;
    for (int k = 0; k < LANES; k++) a[k] = ad[k] - (ad[k] % E);
    f = -1;
    for (int k = LANES - 1; k >= 0; k--) if (act[k]) f = k;
    ok = 1'b1;
    if (f >= 0) begin
      B = a[f] - (a[f] % S0);
      for (int k = 0; k < LANES; k++) if (act[k] && a[k] != B + k * E) ok = 1'b0;
    end
    pend = act;
    e_n = 0;
    while (pend != 0) begin
      int L, S;
      int unsigned m;
      logic fits;
      L = 0;
      while (!pend[L]) L++;
      if (strict && !ok) begin
        m = 1 << L; S = 32;
      end else begin
        S = S0; m = 0;
        for (int k = 0; k < LANES; k++)
          if (pend[k] && a[k] / S == a[L] / S) m |= (1 << k);
        fits = 1'b1;
        while (S > 32 && fits) begin
          for (int k = 0; k < LANES; k++)
            if (m[k] && a[k] / (S / 2) != a[L] / (S / 2)) fits = 1'b0;
          if (fits) S = S / 2;
        end
      end
      e_base[e_n] = a[L] - (a[L] % S);
      e_size[e_n] = (S == 32) ? 0 : (S == 64) ? 1 : 2;
      e_mask[e_n] = m;
      e_n++;
      pend &= ~m;
    end
  endtask

  task automatic run_group(input logic [15:0] act, input int unsigned ad[LANES],
                           input int elem, input logic strict);
    int idx, cyc;
    logic held;
    logic [AW-1:0] hb; logic [1:0] hs; logic [LANES-1:0] hm;
    model(act, ad, elem, strict);
    @(negedge clk); #1;
    chk(grp_ready, "R1 grp_ready idle", grp_ready, 1);
    grp_valid = 1'b1; grp_active = act; grp_elem = 2'(elem); grp_strict = strict;
    for (int k = 0; k < LANES; k++) grp_addr[k*AW +: AW] = ad[k];
    @(posedge clk); @(negedge clk);
    grp_valid = 1'b0;
    idx = 0; cyc = 0; held = 1'b0;
    forever begin
      lfsr = nxt(lfsr);
      txn_ready = (lfsr[1:0] != 2'b00);
      #1;
      chk(!grp_ready, "R1 busy while group open", grp_ready, 0);
      if (held) begin
        chk(txn_valid && txn_base == hb && txn_size == hs && txn_mask == hm,
            "R6 hold while stalled", {txn_base, txn_mask}, {hb, hm});
        held = 1'b0;
      end
      if (grp_done) begin
        chk(idx == e_n, (e_n == 0) ? "R8 empty group count" : "R7 count at done", idx, e_n);
        break;
      end
      if (idx == e_n) begin
        chk(1'b0, (e_n == 0) ? "R8 done after empty accept" : "R7 done after last transfer", 0, 1);
        break;
      end
      if (txn_valid && txn_ready) begin
        chk(txn_base == e_base[idx], "R3 R10 base", txn_base, e_base[idx]);
        chk(txn_size == e_size[idx], "R2 R5 size", txn_size, e_size[idx]);
        chk(txn_mask == e_mask[idx], strict ? "R9 mask" : "R4 mask", txn_mask, e_mask[idx]);
        idx++;
      end else if (txn_valid) begin
        held = 1'b1; hb = txn_base; hs = txn_size; hm = txn_mask;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 200) begin
        chk(1'b0, "R7 group never completed", idx, e_n);
        break;
      end
    end
    @(negedge clk); #1;
    chk(!grp_done, "R7 done single cycle", grp_done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int unsigned ad[LANES];
    logic [15:0] act;
    int E;
    repeat (3) @(negedge clk);
    #1;
    chk(grp_ready == 1'b1, "R1 reset ready", grp_ready, 1);
    chk(txn_valid == 1'b0, "R1 reset txn_valid", txn_valid, 0);
    chk(grp_done == 1'b0, "R1 reset done", grp_done, 0);
    rst_n = 1'b1;
    for (int p = 0; p < 10; p++) begin
      for (int elem = 0; elem < 4; elem++) begin
        for (int st = 0; st < 2; st++) begin
          E = 1 << elem;
          act = 16'hFFFF;
          for (int k = 0; k < LANES; k++) begin
            case (p)
              0: ad[k] = 256 + k * E;
              1: ad[k] = 256 + (k + 1) * E;
              2: ad[k] = 1024 + 2 * k * E;
              3: ad[k] = 384 + (15 - k) * E;
              4: ad[k] = 640 + 3;
              5: ad[k] = 2048 + k * E;
              6: ad[k] = 77 * k;
              7: ad[k] = 4096 + 32 * k;
              8: begin lfsr = nxt(lfsr); ad[k] = lfsr % 512; end
              default: ad[k] = 512 + (k % 4) * E + 1;
            endcase
          end
          if (p == 5) act = 16'hA5A4;
          if (p == 6) act = 16'h0000;
          run_group(act, ad, elem, st[0]);
        end
      end
    end
    for (int r = 0; r < 120; r++) begin
      lfsr = nxt(lfsr);
      act = lfsr[15:0];
      for (int k = 0; k < LANES; k++) begin
        lfsr = nxt(lfsr);
        ad[k] = (r % 3 == 0) ? (lfsr % 1024) : 128 * (r % 5) + k * (1 << (r % 4)) + (lfsr % 2);
      end
      run_group(act, ad, r % 4, r[2]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule